// File: doc/BRIEF.md
# Multichannel Hit Latch with Pile-up Rejection

The block watches 32 synchronous logic timing pulses, one per detector channel, and records which channels fired in the current event. A channel's record is dropped when a second distinct pulse on that channel comes too close in time, either before or after the pulse that set the record. Two rising edges that are closer than a short merge interval count as one pulse. An external enable turns the rejection on or off.

Each channel has a free-running counter of cycles since its last distinct pulse. The counter stops at the guard window length, and a clear from the host does not reset it. Because the counter is compared on every new pulse, one rule covers both directions: a pulse that follows a recent pulse is rejected, and a latched hit is removed when a recent pulse follows it. A live count of the channels whose input is currently high is given for fast coincidence logic. On request, a readout scan returns the addresses of the latched channels in ascending order on a 5-bit bus. The scan waits at any channel whose after-event window is still open.

Top module: `pileup_hit_latch`

## Requirements
- R1: While rst_ni is low and after it is released, mult_o is 0, addr_valid_o and rd_done_o are low, no channel is latched, and every channel counts as having no recent pulse.
- R2: mult_o equals the number of ones in pulse_i sampled at the previous rising clock edge, as an unsigned value from 0 to 32.
- R3: An onset is a cycle in which a channel's input is sampled high after being sampled low. A single onset on a channel with no other onset nearby sets that channel's latch, and the readout reports it.
- R4: When pu_en_i is 1 and an onset follows the previous distinct onset on the same channel by d cycles, with MERGE (10) <= d < WIN (200), the channel's latch is cleared and is not set again by that onset.
- R5: The rejection of R4 also applies when the earlier pulse's latch was already cleared by cready_i, so a pulse shortly after an earlier one is never latched (pile-up before the event).
- R6: An onset less than MERGE cycles after the previous distinct onset is ignored. It does not change the latch and does not restart the channel's counter.
- R7: An onset WIN or more cycles after the previous distinct onset is a new distinct pulse. It leaves an existing latch set.
- R8: When pu_en_i is 0, every distinct onset sets the latch, and a second distinct onset within WIN cycles leaves it set.
- R9: A high cready_i clears every latch at the next edge and takes priority over an onset in the same cycle. It does not affect the counters or mult_o.
- R10: rd_req_i is sampled only while no scan runs. A scan then checks channels 0 to 31 in order. Each latched channel gives one cycle with addr_valid_o high and its index on addr_o. rd_done_o pulses for one cycle in the cycle that channel 31 is reported or skipped. An empty scan gives rd_done_o with no valid cycle.
- R11: When pu_en_i is 1, the scan stalls at a latched channel until WIN cycles have passed since that channel's last distinct onset. A latch cleared during the stall is skipped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pulse_i | input | 32 | Synchronous logic timing pulse, one bit per channel |
| pu_en_i | input | 1 | 1 enables pile-up rejection |
| cready_i | input | 1 | Host ready: clears all hit latches |
| rd_req_i | input | 1 | Starts a readout scan |
| mult_o | output | 6 | Count of channels whose input is high |
| addr_o | output | 5 | Address of a latched channel |
| addr_valid_o | output | 1 | addr_o holds a reported channel |
| rd_done_o | output | 1 | Readout scan finished |

## Verification
A wrong per-channel counter shows up at the ports only through the next readout scan, some 200 or more cycles after the stimulus. It appears as an address that is missing or extra, or that is reported too early. For this reason each timing case is placed on its own channel, with gaps just below and at the merge and window limits, and the results are read back through one scan. A bad readout sequencer shows within 33 cycles of the request, as addresses out of order or a done pulse that comes without the expected addresses. A multiplicity fault shows in the very next cycle.

// File: rtl/phl_pkg.sv
package phl_pkg;
  typedef enum logic {RD_IDLE, RD_SCAN} rd_state_e;
endpackage

// File: rtl/phl_channel.sv
module phl_channel #(
  parameter int WIN   = 200,
  parameter int MERGE = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pulse_i,
  input  logic pu_en_i,
  input  logic clr_i,
  output logic hit_o,
  output logic ready_o
);
  localparam int CW = $clog2(WIN + 1);
  localparam logic [CW-1:0] WIN_C   = CW'(WIN);
  localparam logic [CW-1:0] MERGE_C = CW'(MERGE);

  logic          prev_q;
  logic          hit_q;
  logic [CW-1:0] since_q;  // cycles since last distinct onset, saturating
  logic          onset, merged, distinct, piled;

  assign onset    = pulse_i & ~prev_q;
  assign merged   = onset && (since_q < MERGE_C);
  assign distinct = onset && !merged;
  assign piled    = distinct && pu_en_i && (since_q < WIN_C);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b0;
      since_q <= WIN_C;
      hit_q   <= 1'b0;
    end else begin
      prev_q <= pulse_i;
      if (distinct)             since_q <= CW'(1);
      else if (since_q < WIN_C) since_q <= since_q + 1'b1;
      if (clr_i)         hit_q <= 1'b0;
      else if (piled)    hit_q <= 1'b0;
      else if (distinct) hit_q <= 1'b1;
    end
  end

  assign hit_o   = hit_q;
  assign ready_o = hit_q && (!pu_en_i || since_q == WIN_C);

  AST_SINCE_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    since_q <= WIN_C); // R4
  AST_CLR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !hit_q); // R9
  AST_MERGE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (onset && since_q < MERGE_C && !clr_i) |=> (hit_q == $past(hit_q))); // R6
  AST_PILEUP_KILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (onset && pu_en_i && since_q >= MERGE_C && since_q < WIN_C) |=> !hit_q); // R4
  AST_NOPU_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (onset && !pu_en_i && since_q >= MERGE_C && !clr_i) |=> hit_q); // R8
endmodule

// File: rtl/phl_mult.sv
module phl_mult #(
  parameter int N_CH = 32
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N_CH-1:0]           pulse_i,
  output logic [$clog2(N_CH+1)-1:0] mult_o
);
  localparam int MW = $clog2(N_CH + 1);

  logic [MW-1:0] sum;

  always_comb begin
    sum = '0;
    for (int i = 0; i < N_CH; i++) sum = sum + MW'(pulse_i[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mult_o <= '0;
    else         mult_o <= sum;
  end

  AST_MULT_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> (mult_o == MW'($countones($past(pulse_i))))); // R2
endmodule

// File: rtl/phl_readout.sv
module phl_readout
  import phl_pkg::*;
#(
  parameter int N_CH = 32
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      rd_req_i,
  input  logic [N_CH-1:0]           hit_i,
  input  logic [N_CH-1:0]           ready_i,
  output logic [$clog2(N_CH)-1:0]   addr_o,
  output logic                      valid_o,
  output logic                      done_o
);
  localparam int AW = $clog2(N_CH);
  localparam logic [AW-1:0] LAST = AW'(N_CH - 1);

  rd_state_e     state_q;
  logic [AW-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RD_IDLE;
      idx_q   <= '0;
      addr_o  <= '0;
      valid_o <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      done_o  <= 1'b0;
      case (state_q)
        RD_IDLE: if (rd_req_i) begin
          state_q <= RD_SCAN;
          idx_q   <= '0;
        end
        RD_SCAN: if (!hit_i[idx_q] || ready_i[idx_q]) begin
          // advance past empty channels, stall on open windows
          if (hit_i[idx_q]) begin
            valid_o <= 1'b1;
            addr_o  <= idx_q;
          end
          if (idx_q == LAST) begin
            done_o  <= 1'b1;
            state_q <= RD_IDLE;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: state_q <= RD_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RD_IDLE) |=> !valid_o); // R10
endmodule

// File: rtl/pileup_hit_latch.sv
module pileup_hit_latch #(
  parameter int N_CH  = 32,
  parameter int WIN   = 200,
  parameter int MERGE = 10
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N_CH-1:0]           pulse_i,
  input  logic                      pu_en_i,
  input  logic                      cready_i,
  input  logic                      rd_req_i,
  output logic [$clog2(N_CH+1)-1:0] mult_o,
  output logic [$clog2(N_CH)-1:0]   addr_o,
  output logic                      addr_valid_o,
  output logic                      rd_done_o
);
  logic [N_CH-1:0] hit_w, ready_w;

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    phl_channel #(.WIN(WIN), .MERGE(MERGE)) u_ch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .pulse_i (pulse_i[g]),
      .pu_en_i (pu_en_i),
      .clr_i   (cready_i),
      .hit_o   (hit_w[g]),
      .ready_o (ready_w[g])
    );
  end

  phl_mult #(.N_CH(N_CH)) u_mult (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pulse_i (pulse_i),
    .mult_o  (mult_o)
  );

  phl_readout #(.N_CH(N_CH)) u_rd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_req_i (rd_req_i),
    .hit_i    (hit_w),
    .ready_i  (ready_w),
    .addr_o   (addr_o),
    .valid_o  (addr_valid_o),
    .done_o   (rd_done_o)
  );

  AST_MULT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mult_o <= ($clog2(N_CH+1))'(N_CH)); // R2
endmodule

// File: tb/pileup_hit_latch_bench.sv
module pileup_hit_latch_bench;
  localparam int WIN = 200, MERGE = 10;

  logic        clk = 0, rst_ni = 0;
  logic [31:0] pulse = '0;
  logic        pu_en = 1, cready = 0, rd_req = 0;
  logic [5:0]  mult;
  logic [4:0]  addr;
  logic        valid, done;

  always #4 clk = ~clk;

  pileup_hit_latch u_pileup_hit_latch (
    .clk_i(clk), .rst_ni(rst_ni), .pulse_i(pulse), .pu_en_i(pu_en),
    .cready_i(cready), .rd_req_i(rd_req), .mult_o(mult), .addr_o(addr),
    .addr_valid_o(valid), .rd_done_o(done)
  );

  int    n_tests = 0, n_fail = 0, cyc = 0, done_cnt = 0, last_valid_cyc = 0;
  int    exp_q[$];
  string cur_req = "R1";

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  // monitor: pop expected addresses as the scan produces them
  always @(negedge clk) begin
    if (rst_ni) begin
      if (valid) begin
        int e;
        last_valid_cyc = cyc;
        if (exp_q.size() == 0) check(0, cur_req, int'(addr), -1);
        else begin
          e = exp_q.pop_front();
          check(int'(addr) == e, cur_req, int'(addr), e);
        end
      end
      if (done) begin
        check(exp_q.size() == 0, cur_req, exp_q.size(), 0);
        exp_q.delete();
        done_cnt++;
      end
    end
  end

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic fire(input int c);
    pulse[c] = 1'b1; step(2); pulse[c] = 1'b0;
  endtask

  task automatic pair(input int c, input int d);
    fire(c); step(d - 2); fire(c);
  endtask

  task automatic cr();
    cready = 1'b1; step(1); cready = 1'b0;
  endtask

  task automatic readout(input string req);
    int n0;
    cur_req = req;
    n0 = done_cnt;
    rd_req = 1'b1; step(1); rd_req = 1'b0;
    while (done_cnt == n0) step(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    summary();
    $finish;
  end

  initial begin
    int c0;
    step(3);
    check(mult == 0 && !valid && !done, "R1 in reset", {mult, valid, done}, 0);
    rst_ni = 1'b1;
    step(2);
    check(mult == 0 && !valid && !done, "R1 after reset", {mult, valid, done}, 0);
    exp_q.delete();
    readout("R1 empty scan");

    // R2 multiplicity patterns
    pulse = 32'h0000_00FF; step(1); check(mult == 8,  "R2 0xFF", mult, 8);
    pulse = 32'hFFFF_FFFF; step(1); check(mult == 32, "R2 all", mult, 32);
    pulse = 32'h8000_0001; step(1); check(mult == 2,  "R2 ends", mult, 2);
    pulse = 32'h0000_0000; step(1); check(mult == 0,  "R2 none", mult, 0);

    // R9: cready clears every latch set above
    step(WIN + 5); cr();
    exp_q.delete();
    readout("R9 clear all");

    // R3 single hits, R10 ascending order
    pulse[3] = 1'b1; pulse[17] = 1'b1; step(2); pulse[3] = 1'b0; pulse[17] = 1'b0;
    step(WIN + 5);
    exp_q = '{3, 17};
    readout("R3/R10 single hits");
    cr();

    // R4 after-event pile-up, R7 window boundary
    pair(5, 50);
    fire(6);
    pair(7, WIN - 1);
    pair(8, WIN);
    step(WIN + 5);
    exp_q = '{6, 8};
    readout("R4/R7 window");
    cr();

    // R6 merge interval, counter not restarted by merged edge
    pair(9, 5);
    pair(10, MERGE);
    pair(19, MERGE - 1);
    fire(11); step(3); fire(11); step(194); fire(11);
    step(WIN + 5);
    exp_q = '{9, 11, 19};
    readout("R6 merge");
    cr();

    // R8 rejection disabled
    pu_en = 1'b0;
    pair(12, 50);
    step(WIN + 5);
    exp_q = '{12};
    readout("R8 pile-up off");
    pu_en = 1'b1;
    cr();

    // R5 before-event pile-up across cready, R9 priority and clearing
    pulse[13] = 1'b1; pulse[15] = 1'b1; step(2); pulse[13] = 1'b0; pulse[15] = 1'b0;
    step(20); cr(); step(30);
    fire(13);
    pulse[14] = 1'b1; cready = 1'b1; step(1); cready = 1'b0; step(1); pulse[14] = 1'b0;
    fire(16);
    step(WIN + 5);
    exp_q = '{16};
    readout("R5/R9 before and clear");
    cr();
    step(WIN + 5);

    // R11 scan stalls on an open window; killed latch skipped
    c0 = cyc;
    pulse[20] = 1'b1; pulse[21] = 1'b1; step(2); pulse[20] = 1'b0; pulse[21] = 1'b0;
    step(8);
    exp_q = '{20};
    fork
      readout("R11 stall");
      begin step(90); fire(21); end
    join
    check(last_valid_cyc - c0 >= WIN, "R11 report after window", last_valid_cyc - c0, WIN);

    summary();
    $finish;
  end
endmodule